// File: doc/BRIEF.md
# Blocked DMA Data-Phase Sequencer

This block runs the data phase of a SCSI-style initiator. A command enters with a 32-bit state word and a 32-bit buffer address. The sequencer then asks an external byte mover for transfers. While the block count in the state word is nonzero, each request is a fixed 512-byte block at the current address. After each block, the address moves up by 512 and the count drops by one. The updated address is written back straight away, so a phase change in the middle of a run leaves a pointer the command can resume from.

When the count reaches zero, the sequencer issues one ordinary transfer whose length is set by the mover's own descriptor. It then marks the residue field with 2, writes the state word back and reports completion. A nonzero residue field at that point is an error: too much data for the input direction, too little for the output direction.

The state word is laid out as follows, with byte 0 in bits 7:0:

- byte 0: status
- byte 1: result
- byte 2: block count
- byte 3: residue flag

One data-phase run ends with exactly one done pulse. That pulse carries a reason code.

Top module: `dseq_top`

## Requirements
- R1: After reset, `mv_req`, `addr_we`, `state_we` and `done` are all low until `start` is given.
- R2: While the block count (state bits 23:16) is nonzero, the block raises `mv_req` with `mv_block`=1 and `mv_addr` equal to the current address. It holds the request until `mv_ack`, which means 512 bytes were moved.
- R3: After each acknowledged block, `addr_we` pulses in the next cycle. `addr_wb` then carries the previous address plus 512, formed as follows:
  - byte 0 is unchanged;
  - 2 is added into byte 1;
  - the carry runs through bytes 2 and 3;
  - the result wraps modulo 2^32.
- R4: Each block lowers the block count by exactly one (modulo 256). Blocks repeat while the count is nonzero and `phase_ok` stays high.
- R5: With count zero and residue flag (bits 31:24) zero, one request with `mv_block`=0 is issued. On its acknowledge, the block then:
  - pulses `state_we` with byte 3 set to 2, count 0, and bytes 0 and 1 unchanged;
  - pulses `done` with code 0 (complete).
- R6: If `phase_ok` is low in the cycle after a block, the block pulses `addr_we` and `state_we` together with the latest address and count. It signals `done` with code 1 (phase change) and issues no further request.
- R7: With count zero and residue nonzero in the input direction (`dir_in`=1), `done` pulses with code 2 (too much data). No request and no state write-back follow.
- R8: The same condition in the output direction (`dir_in`=0) gives code 3 (too little data). No request and no state write-back follow.
- R9: `done` is a single-cycle pulse given exactly once per run. `state_we` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a data phase; sampled while idle |
| dir_in | input | 1 | 1 = data into memory, 0 = data out of memory |
| state_in | input | 32 | Command state word |
| addr_in | input | 32 | Starting buffer address |
| phase_ok | input | 1 | Bus is still in the matching data phase |
| mv_ack | input | 1 | Byte mover finished the requested transfer |
| mv_req | output | 1 | Transfer request to the byte mover |
| mv_block | output | 1 | 1 = fixed 512-byte block, 0 = ordinary transfer |
| mv_dir | output | 1 | Direction of the requested transfer |
| mv_addr | output | 32 | Address for a block transfer |
| addr_wb | output | 32 | Address write-back value |
| addr_we | output | 1 | Address write-back strobe |
| state_wb | output | 32 | State word write-back value |
| state_we | output | 1 | State word write-back strobe |
| done | output | 1 | End of data phase pulse |
| done_code | output | 2 | 0 complete, 1 phase change, 2 too much data, 3 too little data |

## Verification
The bench builds the block with its default parameters: 512-byte blocks and a four-byte address. This keeps every byte of the carry chain reachable with only one or two blocks. Starting addresses are chosen so that byte 1 overflows into byte 3, and so that the whole address wraps past 2^32. Block counts stay small, so the phase-drop cases can land both in the middle of a run and on its very last block. Residue is also set beside a nonzero count, which exercises the error raised after the block loop.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_BLK,
    S_POST,
    S_ONE,
    S_FIN
  } seq_st_t;

  typedef enum logic [1:0] {
    DONE_OK    = 2'd0,
    DONE_PHASE = 2'd1,
    DONE_OVER  = 2'd2,
    DONE_UNDER = 2'd3
  } done_code_t;

  localparam logic [7:0] RESIDUE_AFTER_ONE = 8'd2;

  // block count decrement by modular addition of 255
  function automatic logic [7:0] cnt_dec(input logic [7:0] c);
    return c + 8'hFF;
  endfunction

  function automatic logic [7:0] sw_cnt(input logic [31:0] w);
    return w[23:16];
  endfunction

  function automatic logic [7:0] sw_res(input logic [31:0] w);
    return w[31:24];
  endfunction

endpackage

// File: rtl/dseq_addr_adv.sv
module dseq_addr_adv #(
  parameter int BLK_BYTES  = 512,
  parameter int ADDR_BYTES = 4
) (
  input  logic [ADDR_BYTES*8-1:0] cur,
  output logic [ADDR_BYTES*8-1:0] nxt
);
  localparam int STEP = BLK_BYTES / 256;

  logic [ADDR_BYTES-1:1] cy;

  assign nxt[7:0] = cur[7:0];

  for (genvar i = 1; i < ADDR_BYTES; i++) begin : g_byte
    logic [8:0] sum;
    if (i == 1) begin : g_first
      assign sum = {1'b0, cur[15:8]} + 9'(STEP);
    end else begin : g_rest
      assign sum = {1'b0, cur[8*i +: 8]} + {8'd0, cy[i-1]};
    end
    assign nxt[8*i +: 8] = sum[7:0];
    assign cy[i]         = sum[8];
  end

  // R3: the top carry marks a wrap of the whole pointer
  always_comb begin
    if (cy[ADDR_BYTES-1]) a_r3_wrap_lower : assert (nxt < cur);
    else                  a_r3_no_wrap_higher : assert (nxt > cur);
  end

endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int AW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_in,
  input  logic [31:0]   state_in,
  input  logic [AW-1:0] addr_in,
  input  logic          phase_ok,
  input  logic          mv_ack,
  input  logic [AW-1:0] ad_nxt,
  output logic [AW-1:0] ad,
  output logic [31:0]   sw,
  output logic          dir,
  output logic          mv_req,
  output logic          mv_block,
  output logic          addr_we,
  output logic          state_we,
  output logic          done,
  output logic [1:0]    done_code
);

  seq_st_t st;

  logic [7:0] cnt, res;
  logic       cnt_zero, res_err, ev_block_end, ev_phase_lost, ev_err, ev_fin;

  assign cnt      = sw_cnt(sw);
  assign res      = sw_res(sw);
  assign cnt_zero = (cnt == 8'd0);

  // named internal events
  assign ev_block_end  = (st == S_BLK) && mv_ack;
  assign ev_phase_lost = (st == S_POST) && !phase_ok;
  assign res_err       = cnt_zero && (res != 8'd0);
  assign ev_err        = (st == S_CHECK) && res_err;
  assign ev_fin        = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      ad  <= '0;
      sw  <= '0;
      dir <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          ad  <= addr_in;
          sw  <= state_in;
          dir <= dir_in;
          st  <= S_CHECK;
        end
        S_CHECK: begin
          if (!cnt_zero)    st <= S_BLK;
          else if (res_err) st <= S_IDLE;
          else              st <= S_ONE;
        end
        S_BLK: if (mv_ack) begin
          ad         <= ad_nxt;
          sw[23:16]  <= cnt_dec(cnt);
          st         <= S_POST;
        end
        S_POST: st <= phase_ok ? S_CHECK : S_IDLE;
        S_ONE: if (mv_ack) begin
          sw[31:24] <= RESIDUE_AFTER_ONE;
          st        <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mv_req   = (st == S_BLK) || (st == S_ONE);
  assign mv_block = (st == S_BLK);
  assign addr_we  = (st == S_POST);
  assign state_we = ev_phase_lost || ev_fin;
  assign done     = ev_err || ev_phase_lost || ev_fin;

  always_comb begin
    if (ev_err)             done_code = dir ? DONE_OVER : DONE_UNDER;
    else if (ev_phase_lost) done_code = DONE_PHASE;
    else                    done_code = DONE_OK;
  end

  // R2: a block request is held until acknowledged
  a_r2_req_held : assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && !mv_ack) |=> mv_req);

  // R2: the block address is stable while waiting
  a_r2_addr_stable : assert property (@(posedge clk) disable iff (!rst_n)
    (mv_block && !mv_ack) |=> $stable(ad));

  // R3: write-back follows the acknowledged block by one cycle
  a_r3_wb_after_block : assert property (@(posedge clk) disable iff (!rst_n)
    ev_block_end |=> addr_we);

  // R3: the pointer moved by one block length
  a_r3_step : assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |-> (ad == $past(ad) + AW'(BLK_BYTES)));

  // R4: one count per block
  a_r4_cnt_dec : assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |-> (cnt == $past(cnt) - 8'd1));

  // R7, R8: errors write nothing back
  a_r7_err_no_wb : assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code[1]) |-> (!state_we && !addr_we && !mv_req));

  // R9: single-cycle done, state write-back only with done
  a_r9_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_swe_with_done : assert property (@(posedge clk) disable iff (!rst_n)
    state_we |-> done);

endmodule

// File: rtl/dseq_top.sv
module dseq_top #(
  parameter int BLK_BYTES  = 512,
  parameter int ADDR_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    dir_in,
  input  logic [31:0]             state_in,
  input  logic [ADDR_BYTES*8-1:0] addr_in,
  input  logic                    phase_ok,
  input  logic                    mv_ack,
  output logic                    mv_req,
  output logic                    mv_block,
  output logic                    mv_dir,
  output logic [ADDR_BYTES*8-1:0] mv_addr,
  output logic [ADDR_BYTES*8-1:0] addr_wb,
  output logic                    addr_we,
  output logic [31:0]             state_wb,
  output logic                    state_we,
  output logic                    done,
  output logic [1:0]              done_code
);
  localparam int AW = ADDR_BYTES * 8;

  logic [AW-1:0] ad, ad_nxt;
  logic [31:0]   sw;
  logic          dir;

  dseq_addr_adv #(.BLK_BYTES(BLK_BYTES), .ADDR_BYTES(ADDR_BYTES)) u_adv (
    .cur (ad),
    .nxt (ad_nxt)
  );

  dseq_ctrl #(.BLK_BYTES(BLK_BYTES), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dir_in    (dir_in),
    .state_in  (state_in),
    .addr_in   (addr_in),
    .phase_ok  (phase_ok),
    .mv_ack    (mv_ack),
    .ad_nxt    (ad_nxt),
    .ad        (ad),
    .sw        (sw),
    .dir       (dir),
    .mv_req    (mv_req),
    .mv_block  (mv_block),
    .addr_we   (addr_we),
    .state_we  (state_we),
    .done      (done),
    .done_code (done_code)
  );

  assign mv_dir   = dir;
  assign mv_addr  = ad;
  assign addr_wb  = ad;
  assign state_wb = sw;

endmodule

// File: tb/sim_dseq_top.sv
module sim_dseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_in = 1'b0;
  logic [31:0] state_in = '0;
  logic [31:0] addr_in = '0;
  logic        phase_ok = 1'b1;
  logic        mv_ack = 1'b0;
  logic        mv_req, mv_block, mv_dir, addr_we, state_we, done;
  logic [31:0] mv_addr, addr_wb, state_wb;
  logic [1:0]  done_code;

  always #2 clk = ~clk;

  dseq_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in),
    .state_in(state_in), .addr_in(addr_in), .phase_ok(phase_ok),
    .mv_ack(mv_ack), .mv_req(mv_req), .mv_block(mv_block),
    .mv_dir(mv_dir), .mv_addr(mv_addr), .addr_wb(addr_wb),
    .addr_we(addr_we), .state_wb(state_wb), .state_we(state_we),
    .done(done), .done_code(done_code)
  );

  int checks = 0;
  int errors = 0;

  // observations collected by the responder/monitor
  int          nblk, nsgl, nawe, nswe, ndone, addr_bad, wide_done;
  int          drop_after;
  logic [31:0] exp_blk_addr, last_awb, last_swb;
  logic [1:0]  last_code;
  logic        prev_done;

  task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // mover model and output monitor, one process at the falling edge
  initial begin
    int wait_c = 0;
    forever begin
      @(negedge clk);
      if (addr_we) begin nawe++; last_awb = addr_wb; end
      if (state_we) begin nswe++; last_swb = state_wb; end
      if (done) begin ndone++; last_code = done_code; end
      if (done && prev_done) wide_done++;
      prev_done = done;
      if (mv_ack) begin
        mv_ack = 1'b0;
      end else if (mv_req) begin
        wait_c++;
        if (wait_c == 2) begin
          wait_c = 0;
          mv_ack = 1'b1;
          if (mv_block) begin
            if (mv_addr !== exp_blk_addr) addr_bad++;
            exp_blk_addr = exp_blk_addr + 32'd512;
            nblk++;
            if (nblk == drop_after) phase_ok = 1'b0;
          end else begin
            nsgl++;
          end
        end
      end
    end
  end

  task automatic run_case(input string tag, input logic d, input logic [31:0] sw,
                          input logic [31:0] a, input int drop);
    int cnt, res, eb, es, ea, ew;
    logic [1:0]  ec;
    logic [31:0] est, ead;
    cnt = int'(sw[23:16]);
    res = int'(sw[31:24]);
    if (drop >= 1 && drop <= cnt) begin
      eb = drop; es = 0; ec = 2'd1; ew = 1;
      est = {sw[31:24], 8'(cnt - drop), sw[15:0]};
    end else if (res != 0) begin
      eb = cnt; es = 0; ec = d ? 2'd2 : 2'd3; ew = 0; est = '0;
    end else begin
      eb = cnt; es = 1; ec = 2'd0; ew = 1;
      est = {8'd2, 8'd0, sw[15:0]};
    end
    ea  = eb;
    ead = a + 32'(eb * 512);
    nblk = 0; nsgl = 0; nawe = 0; nswe = 0; ndone = 0; addr_bad = 0; wide_done = 0;
    drop_after = drop; exp_blk_addr = a; phase_ok = 1'b1;
    @(negedge clk);
    dir_in = d; state_in = sw; addr_in = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20000 && ndone == 0; k++) @(posedge clk);
    repeat (6) @(posedge clk);
    chk({tag, " done once"}, ndone == 1 && wide_done == 0, ndone, 1);
    chk({tag, " code"}, last_code == ec, last_code, ec);
    chk({tag, " blocks"}, nblk == eb, nblk, eb);
    chk({tag, " block addr"}, addr_bad == 0, addr_bad, 0);
    chk({tag, " single xfer"}, nsgl == es, nsgl, es);
    chk({tag, " addr wb count"}, nawe == ea, nawe, ea);
    if (ea > 0) chk({tag, " addr wb"}, last_awb == ead, last_awb, ead);
    chk({tag, " state wb count"}, nswe == ew, nswe, ew);
    if (ew > 0) chk({tag, " state wb"}, last_swb == est, last_swb, est);
    phase_ok = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: quiet after reset
    chk("R1 reset outputs", !mv_req && !addr_we && !state_we && !done, {mv_req, addr_we, state_we, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", !mv_req && !done, {mv_req, done}, 0);
    // R2 R4 R5: three blocks then the ordinary transfer, input direction
    run_case("R2_R4_R5 run", 1'b1, 32'h0003_5AA5, 32'h0010_0040, 0);
    // R3: carry out of byte 1 through byte 3, output direction
    run_case("R3 carry", 1'b0, 32'h0002_0000, 32'h12FF_FF34, 0);
    // R3: full wrap of the pointer
    run_case("R3 wrap", 1'b1, 32'h0001_0011, 32'hFFFF_FE10, 0);
    // R6: phase lost mid-run
    run_case("R6 mid", 1'b1, 32'h0005_0000, 32'h0000_2000, 2);
    // R6: phase lost on the final block
    run_case("R6 last", 1'b0, 32'h0002_0703, 32'h0000_8100, 2);
    // R7: residue set, input direction
    run_case("R7 over", 1'b1, 32'h0100_0000, 32'h0000_4000, 0);
    // R7: residue found after a block
    run_case("R7 after block", 1'b1, 32'h0101_0000, 32'h0000_0600, 0);
    // R8: residue set, output direction
    run_case("R8 under", 1'b0, 32'h0700_0000, 32'h0000_4000, 0);
    // R5 R9: ordinary transfer only
    run_case("R5_R9 single", 1'b1, 32'h0000_3322, 32'hABCD_0000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule